// File: doc/BRIEF.md
# Lowest-Set-Bit Clearing Execution Unit

This unit sits in the execute stage of a processor pipeline. It takes a source operand, clears the least significant bit that is 1 and keeps every other bit, then returns the result together with a set of condition flags. The operand width is chosen from the processor mode and a width-select field from the decoder. Results come out one clock after the request.

Two cases are illegal: a nonzero vector-length field, and issue while the processor is in real mode or virtual-8086 mode. Either raises an invalid-opcode fault. When a fault is raised, the destination and the flags keep their previous values. Two flags have no defined value, so the unit drives them low and raises a marker beside each one. A consumer then knows the flag is not meaningful.

Top module: `rlsb_unit`

## Requirements
- R1: For a legal request, the destination equals operand AND (operand minus one), computed at the active width. Exactly the lowest 1 bit is cleared.
- R2: Outside 64-bit mode the active width is 32 bits whatever the width-select input is. The upper 32 bits of `dst_o` are then 0.
- R3: In 64-bit mode, `wide_sel_i`=1 selects 64 bits. `wide_sel_i`=0 selects 32 bits, and the upper 32 destination bits are then 0.
- R4: `sign_o` equals the result bit at position width-1: bit 63 for the wide case, bit 31 for the narrow case.
- R5: `zero_o` is 1 exactly when the result is zero.
- R6: `carry_o` is 1 exactly when the source operand at the active width is zero. For the narrow case this means bits 31:0 of `src_i` are zero.
- R7: After every legal request, `ovf_o`, `aux_o` and `par_o` are 0, and `aux_undef_o` and `par_undef_o` are 1.
- R8: A request raises `fault_o`=1 when `vlen_i` is nonzero, when `mode_real_i` is 1, or when `mode_v86_i` is 1. The destination, flags and undefined markers then keep the values from the last legal request. A legal request drives `fault_o`=0.
- R9: `out_valid` is 1 exactly one clock after a cycle with `in_valid`=1 and is otherwise 0. Results and the fault are presented in that same cycle.
- R10: Synchronous active-high `rst` clears `out_valid`, `fault_o`, `dst_o`, all flags and both undefined markers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_i | input | 64 | Source operand |
| mode_long_i | input | 1 | Processor is in 64-bit mode |
| mode_real_i | input | 1 | Processor is in real mode |
| mode_v86_i | input | 1 | Processor is in virtual-8086 mode |
| wide_sel_i | input | 1 | Decoded width-select field |
| vlen_i | input | 1 | Decoded vector-length field |
| out_valid | output | 1 | Result strobe, one cycle after request |
| dst_o | output | 64 | Destination result |
| sign_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag (source was zero) |
| ovf_o | output | 1 | Overflow flag, always cleared |
| aux_o | output | 1 | Auxiliary-carry flag (undefined, driven 0) |
| par_o | output | 1 | Parity flag (undefined, driven 0) |
| aux_undef_o | output | 1 | Marks aux_o as undefined |
| par_undef_o | output | 1 | Marks par_o as undefined |
| fault_o | output | 1 | Invalid-opcode fault |

## Verification
Two things can happen in the same cycle: the fault decision, and the result and flag computation. The interesting case is a request that would set both the zero and carry flags, such as a zero source, issued with a nonzero vector length or in real or virtual-8086 mode. The bench provokes this and judges it by the fault output. It also checks that the destination and every flag still equal the values from the preceding legal request. A second collision is width selection against flag generation: a 64-bit-mode narrow request with upper source bits set must give carry and zero from the low half only.

// File: rtl/rlsb_pkg.sv
package rlsb_pkg;

    typedef enum logic {
        OPW_NARROW = 1'b0,
        OPW_WIDE   = 1'b1
    } opw_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic carry;
        logic ovf;
        logic aux;
        logic par;
    } flags_t;

    typedef struct packed {
        logic aux;
        logic par;
    } undef_t;

endpackage

// File: rtl/rlsb_mode_decode.sv
module rlsb_mode_decode
    import rlsb_pkg::*;
#(
    parameter int VL_W = 1
) (
    input  logic            mode_long,
    input  logic            mode_real,
    input  logic            mode_v86,
    input  logic            wide_sel,
    input  logic [VL_W-1:0] vlen,
    output opw_e            opw,
    output logic            illegal
);

    always_comb begin
        illegal = mode_real || mode_v86 || (vlen != '0);
        if (mode_long && wide_sel) begin
            opw = OPW_WIDE;
        end else begin
            opw = OPW_NARROW;
        end
    end

endmodule

// File: rtl/rlsb_clear_core.sv
module rlsb_clear_core
    import rlsb_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  opw_e              opw,
    output logic [DATA_W-1:0] res,
    output logic              src_zero,
    output logic              res_msb
);

    logic [DATA_W-1:0] narrow_mask;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] less_one;

    generate
        if (DATA_W > NARROW_W) begin : g_split
            assign narrow_mask = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        end else begin : g_flat
            assign narrow_mask = '1;
        end
    endgenerate

    always_comb begin
        operand  = (opw == OPW_WIDE) ? src : (src & narrow_mask);
        less_one = operand - 1'b1;
        res      = operand & less_one;
        src_zero = (operand == '0);
        res_msb  = (opw == OPW_WIDE) ? res[DATA_W-1] : res[NARROW_W-1];
    end

endmodule

// File: rtl/rlsb_flag_gen.sv
module rlsb_flag_gen
    import rlsb_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] res,
    input  logic              src_zero,
    input  logic              res_msb,
    output flags_t            flags,
    output undef_t            undef
);

    always_comb begin
        flags.sign  = res_msb;
        flags.zero  = (res == '0);
        flags.carry = src_zero;
        flags.ovf   = 1'b0;
        flags.aux   = 1'b0;
        flags.par   = 1'b0;
        undef.aux   = 1'b1;
        undef.par   = 1'b1;
    end

endmodule

// File: rtl/rlsb_unit.sv
module rlsb_unit
    import rlsb_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int VL_W     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_i,
    input  logic              mode_long_i,
    input  logic              mode_real_i,
    input  logic              mode_v86_i,
    input  logic              wide_sel_i,
    input  logic [VL_W-1:0]   vlen_i,
    output logic              out_valid,
    output logic [DATA_W-1:0] dst_o,
    output logic              sign_o,
    output logic              zero_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              aux_o,
    output logic              par_o,
    output logic              aux_undef_o,
    output logic              par_undef_o,
    output logic              fault_o
);

    localparam int UPPER_W = DATA_W - NARROW_W;

    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [DATA_W-1:0] dst;
        flags_t            flags;
        undef_t            undef;
    } state_t;

    opw_e              opw;
    logic              illegal;
    logic [DATA_W-1:0] res;
    logic              src_zero;
    logic              res_msb;
    flags_t            flags_c;
    undef_t            undef_c;
    state_t            st_d;
    state_t            st_q;

    rlsb_mode_decode #(.VL_W(VL_W)) u_decode (
        .mode_long (mode_long_i),
        .mode_real (mode_real_i),
        .mode_v86  (mode_v86_i),
        .wide_sel  (wide_sel_i),
        .vlen      (vlen_i),
        .opw       (opw),
        .illegal   (illegal)
    );

    rlsb_clear_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
        .src      (src_i),
        .opw      (opw),
        .res      (res),
        .src_zero (src_zero),
        .res_msb  (res_msb)
    );

    rlsb_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .res      (res),
        .src_zero (src_zero),
        .res_msb  (res_msb),
        .flags    (flags_c),
        .undef    (undef_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.fault = illegal;
            if (!illegal) begin
                st_d.dst   = res;
                st_d.flags = flags_c;
                st_d.undef = undef_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign fault_o     = st_q.fault;
    assign dst_o       = st_q.dst;
    assign sign_o      = st_q.flags.sign;
    assign zero_o      = st_q.flags.zero;
    assign carry_o     = st_q.flags.carry;
    assign ovf_o       = st_q.flags.ovf;
    assign aux_o       = st_q.flags.aux;
    assign par_o       = st_q.flags.par;
    assign aux_undef_o = st_q.undef.aux;
    assign par_undef_o = st_q.undef.par;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && fault_o) |-> ($stable(dst_o) && $stable(zero_o) && $stable(carry_o)));

    // R6
    carry_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !fault_o && carry_o) |-> zero_o);

    // R2
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_long_i && !mode_real_i && !mode_v86_i && (vlen_i == '0))
        |=> (dst_o[DATA_W-1:NARROW_W] == {UPPER_W{1'b0}}));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !fault_o) |-> (!ovf_o && aux_undef_o && par_undef_o));

endmodule

// File: tb/tb_rlsb_unit.sv
module tb_rlsb_unit;

    localparam int NV = 13;
    // {long, real, v86, wide, vlen, src[63:0], exp[63:0], sign, zero, carry, fault}
    localparam logic [136:0] VECS [NV] = '{
        {5'b10010, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_00E0, 4'b0000},
        {5'b10010, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 4'b0110},
        {5'b10010, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 4'b0100},
        {5'b10010, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 4'b1000},
        {5'b10011, 64'h0000_0000_0000_0000, 64'h0,                   4'b0001},
        {5'b10000, 64'hFFFF_FFFF_8000_0001, 64'h0000_0000_8000_0000, 4'b1000},
        {5'b10000, 64'h1234_5678_0000_0000, 64'h0000_0000_0000_0000, 4'b0110},
        {5'b01000, 64'h0000_0000_0000_0005, 64'h0,                   4'b0001},
        {5'b00010, 64'hFFFF_FFFF_0000_0006, 64'h0000_0000_0000_0004, 4'b0000},
        {5'b00000, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000, 4'b0100},
        {5'b00100, 64'h0000_0000_0000_0000, 64'h0,                   4'b0001},
        {5'b10010, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0000, 4'b0100},
        {5'b10010, 64'h0000_0000_0000_0006, 64'h0000_0000_0000_0004, 4'b0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] src_i = '0;
    logic        mode_long_i = 1'b0;
    logic        mode_real_i = 1'b0;
    logic        mode_v86_i = 1'b0;
    logic        wide_sel_i = 1'b0;
    logic [0:0]  vlen_i = '0;
    logic        out_valid;
    logic [63:0] dst_o;
    logic        sign_o, zero_o, carry_o, ovf_o, aux_o, par_o;
    logic        aux_undef_o, par_undef_o, fault_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] held_dst = '0;
    logic [2:0]  held_szc = '0;

    always #2.5 clk = ~clk;

    rlsb_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_i(src_i),
        .mode_long_i(mode_long_i), .mode_real_i(mode_real_i),
        .mode_v86_i(mode_v86_i), .wide_sel_i(wide_sel_i), .vlen_i(vlen_i),
        .out_valid(out_valid), .dst_o(dst_o), .sign_o(sign_o),
        .zero_o(zero_o), .carry_o(carry_o), .ovf_o(ovf_o), .aux_o(aux_o),
        .par_o(par_o), .aux_undef_o(aux_undef_o), .par_undef_o(par_undef_o),
        .fault_o(fault_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [136:0] v);
        @(negedge clk);
        {mode_long_i, mode_real_i, mode_v86_i, wide_sel_i, vlen_i} = v[136:132];
        src_i    = v[131:68];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic judge(input logic [136:0] v, input int idx);
        string tag;
        tag = $sformatf("vec%0d", idx);
        check({"R9 valid ", tag}, {63'd0, out_valid}, 64'd1);
        check({"R8 fault ", tag}, {63'd0, fault_o}, {63'd0, v[0]});
        if (v[0]) begin
            // R8: fault leaves earlier result and flags untouched
            check({"R8 held dst ", tag}, dst_o, held_dst);
            check({"R8 held flags ", tag}, {61'd0, sign_o, zero_o, carry_o}, {61'd0, held_szc});
        end else begin
            // R1 R2 R3 result; R4 R5 R6 flags
            check({"R1 dst ", tag}, dst_o, v[67:4]);
            check({"R4 sign ", tag}, {63'd0, sign_o}, {63'd0, v[3]});
            check({"R5 zero ", tag}, {63'd0, zero_o}, {63'd0, v[2]});
            check({"R6 carry ", tag}, {63'd0, carry_o}, {63'd0, v[1]});
            check({"R7 fixed flags ", tag},
                  {59'd0, ovf_o, aux_o, par_o, aux_undef_o, par_undef_o}, 64'h3);
            held_dst = v[67:4];
            held_szc = v[3:1];
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset valid", {63'd0, out_valid}, 64'd0);
        check("R10 reset dst", dst_o, 64'd0);
        check("R10 reset flags/markers/fault",
              {53'd0, sign_o, zero_o, carry_o, ovf_o, aux_o, par_o,
               aux_undef_o, par_undef_o, fault_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle valid", {63'd0, out_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i]);
            judge(VECS[i], i);
            @(negedge clk);
            check("R9 valid drops", {63'd0, out_valid}, 64'd0);
        end

        // R8 collision: zero source with illegal vlen after a nonzero result
        issue({5'b10010, 64'h0000_0000_0000_000C, 64'h0000_0000_0000_0008, 4'b0000});
        judge({5'b10010, 64'h0000_0000_0000_000C, 64'h0000_0000_0000_0008, 4'b0000}, 100);
        issue({5'b10011, 64'h0, 64'h0, 4'b0001});
        judge({5'b10011, 64'h0, 64'h0, 4'b0001}, 101);

        // R9 back-to-back requests
        @(negedge clk);
        {mode_long_i, mode_real_i, mode_v86_i, wide_sel_i, vlen_i} = 5'b10010;
        src_i    = 64'h0000_0000_0000_0003;
        in_valid = 1'b1;
        @(negedge clk);
        src_i = 64'h0000_0000_0000_0018;
        check("R1 back-to-back first", dst_o, 64'h2);
        check("R9 back-to-back valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 back-to-back second", dst_o, 64'h10);

        // R10 reset during activity
        @(negedge clk);
        in_valid = 1'b1;
        rst      = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 mid reset valid", {63'd0, out_valid}, 64'd0);
        check("R10 mid reset dst", dst_o, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule